// File: doc/BRIEF.md
# Return-Address Stack with Register Move Port

This block keeps a last-in first-out store of program-counter values for a sequencer. A subroutine call or an interrupt entry pushes a return address; a subroutine return or an explicit discard command removes the top entry and throws its value away. A return from interrupt also removes one entry on its own. The current top entry is always visible on an output.

A register-move port lets software reach the stack directly. A read move copies the top entry into a result register and removes that entry one cycle later. A write move pushes the supplied value at once. Both moves name the register on the other side of the transfer. Only data-unit registers and the lower half of each address-generator bank are accepted. Any other code is refused, and the stack is left as it was.

The block reports single-cycle error pulses for a push into a full stack, a removal from an empty stack, a refused register code, and a return from interrupt that lands on a delayed removal still pending. Depth and address width are parameters. The default depth is 16.

Top module: `pcstk_top`

## Requirements
- R1: While reset is held, and for the cycles after the synchronised reset release until the first command, `stk_empty` is 1, `stk_full` is 0, and `top_addr`, `mv_rdata` and all four error outputs are 0.
- R2: `call_push` stores `call_addr` as the new top, visible on `top_addr` in the next cycle. `stk_full` is 1 exactly when DEPTH entries are held. `stk_empty` is 1 exactly when none are held.
- R3: A push (by `call_push` or an accepted write move) while DEPTH entries are held is dropped and pulses `ovf_err` in the next cycle. The contents and `top_addr` are unchanged.
- R4: `ret_pop` removes the top entry without delivering it anywhere. `mv_rdata` keeps its value.
- R5: Any removal attempted while the stack is empty pulses `unf_err` in the next cycle and leaves the stack empty.
- R6: An accepted read move loads `mv_rdata` (valid the next cycle) with the top entry as it stands after any removal applied in the same cycle. The entry is removed one cycle after the move, and the stack is unchanged in between.
- R7: An accepted write move pushes `mv_wdata` in the cycle it is issued. The value is on `top_addr` in the next cycle.
- R8: When a delayed removal falls in the same cycle as another command, the removal is applied first and the command second.
- R9: `rti_pop` removes one entry in addition to any pending delayed removal. When both fall in one cycle, `rti_hazard` pulses in the next cycle.
- R10: Register code `mv_reg` is accepted when it is below 16 (data-unit registers), or when bit 3 is 0 for codes 16 to 63 (banks 16-23, 32-39, 48-55). A refused code pulses `reg_err` in the next cycle, with no push, no removal, no `mv_rdata` change and no delayed removal scheduled.
- R11: An accepted read move that finds the stack empty (after any removal in that cycle) pulses `unf_err`. It schedules no removal and leaves `mv_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| call_push | input | 1 | Push `call_addr` (call or interrupt entry) |
| call_addr | input | AW | Return address to push |
| ret_pop | input | 1 | Discard top entry (return or plain pop) |
| rti_pop | input | 1 | Return from interrupt, discards top entry |
| mv_read | input | 1 | Read move: copy top, remove it a cycle later |
| mv_write | input | 1 | Write move: push `mv_wdata` now |
| mv_reg | input | 6 | Register code of the move's other operand |
| mv_wdata | input | AW | Value for a write move |
| top_addr | output | AW | Current top entry, 0 when empty |
| mv_rdata | output | AW | Result register of the last accepted read move |
| stk_empty | output | 1 | No entries held |
| stk_full | output | 1 | DEPTH entries held |
| ovf_err | output | 1 | Pulse: push dropped on full stack |
| unf_err | output | 1 | Pulse: removal attempted on empty stack |
| reg_err | output | 1 | Pulse: move refused for its register code |
| rti_hazard | output | 1 | Pulse: interrupt return met a pending delayed removal |

## Verification
The assertions assume the instruction decoder raises at most one of the five command inputs in any cycle. The checker states this assumption as a property of its own. The stimulus picks exactly one command, or none, per cycle, so the assumption always holds. Within that rule, the random phase still places commands directly after read moves. This exercises the same-cycle ordering of R8 and the hazard of R9. Directed runs push past full, remove past empty, and send refused register codes.

// File: rtl/pcstk_pkg.sv
package pcstk_pkg;
  localparam int REG_W = 6;

  // Data-unit codes 0..15 are all usable; in each address-generator bank
  // (16, 32, 48) only the lower eight codes are usable.
  function automatic logic reg_code_ok(input logic [REG_W-1:0] code);
    return (code[5:4] == 2'b00) || !code[3];
  endfunction
endpackage

// File: rtl/pcstk_rstsync.sv
module pcstk_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pcstk_ctrl.sv
module pcstk_ctrl
  import pcstk_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             call_push,
  input  logic             ret_pop,
  input  logic             rti_pop,
  input  logic             mv_read,
  input  logic             mv_write,
  input  logic [REG_W-1:0] mv_reg,
  output logic             wr_en,
  output logic [IW-1:0]    wr_idx,
  output logic             rd_cap,
  output logic [IW-1:0]    rd_idx,
  output logic [IW-1:0]    top_idx,
  output logic             top_vld,
  output logic [CW-1:0]    cnt,
  output logic             pend,
  output logic             ovf_err,
  output logic             unf_err,
  output logic             reg_err,
  output logic             rti_hazard
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          ovf_q, ovf_d, unf_q, unf_d, rerr_q, rerr_d, haz_q, haz_d;
  logic          legal, rd_ok, wr_ok;

  always_comb begin
    logic [CW-1:0] c1, c2;
    legal  = reg_code_ok(mv_reg);
    rd_ok  = mv_read && legal;
    wr_ok  = mv_write && legal;
    unf_d  = 1'b0;
    ovf_d  = 1'b0;
    rerr_d = (mv_read || mv_write) && !legal;
    haz_d  = rti_pop && pend_q;
    pend_d = 1'b0;
    wr_en  = 1'b0;
    rd_cap = 1'b0;
    // delayed removal goes first
    c1 = cnt_q;
    if (pend_q) begin
      if (cnt_q == '0) unf_d = 1'b1;
      else             c1 = cnt_q - 1'b1;
    end
    // then the command of this cycle
    c2 = c1;
    if (ret_pop || rti_pop) begin
      if (c1 == '0) unf_d = 1'b1;
      else          c2 = c1 - 1'b1;
    end
    rd_idx = IW'(c2 - 1'b1);
    if (rd_ok) begin
      if (c2 == '0) unf_d = 1'b1;
      else begin
        rd_cap = 1'b1;
        pend_d = 1'b1;
      end
    end
    wr_idx = IW'(c2);
    cnt_d  = c2;
    if (call_push || wr_ok) begin
      if (c2 == FULL_CNT) ovf_d = 1'b1;
      else begin
        wr_en = 1'b1;
        cnt_d = c2 + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
      rerr_q <= 1'b0;
      haz_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
      rerr_q <= rerr_d;
      haz_q  <= haz_d;
    end
  end

  assign top_idx    = IW'(cnt_q - 1'b1);
  assign top_vld    = (cnt_q != '0);
  assign cnt        = cnt_q;
  assign pend       = pend_q;
  assign ovf_err    = ovf_q;
  assign unf_err    = unf_q;
  assign reg_err    = rerr_q;
  assign rti_hazard = haz_q;
endmodule

// File: rtl/pcstk_store.sv
module pcstk_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 14,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic          rd_cap,
  input  logic [IW-1:0] rd_idx,
  input  logic [IW-1:0] top_idx,
  input  logic          top_vld,
  output logic [AW-1:0] top_addr,
  output logic [AW-1:0] rd_data
);
  logic [AW-1:0] ent [DEPTH];
  logic [AW-1:0] rd_q, rd_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (sel) ent[g] <= wr_data;
    end
  end

  always_comb rd_d = rd_cap ? ent[rd_idx] : rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign top_addr = top_vld ? ent[top_idx] : '0;
  assign rd_data  = rd_q;
endmodule

// File: rtl/pcstk_top.sv
module pcstk_top
  import pcstk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 14,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             call_push,
  input  logic [AW-1:0]    call_addr,
  input  logic             ret_pop,
  input  logic             rti_pop,
  input  logic             mv_read,
  input  logic             mv_write,
  input  logic [REG_W-1:0] mv_reg,
  input  logic [AW-1:0]    mv_wdata,
  output logic [AW-1:0]    top_addr,
  output logic [AW-1:0]    mv_rdata,
  output logic             stk_empty,
  output logic             stk_full,
  output logic             ovf_err,
  output logic             unf_err,
  output logic             reg_err,
  output logic             rti_hazard
);
  logic          rst_sync_n;
  logic          wr_en, rd_cap, top_vld, pend_w;
  logic [IW-1:0] wr_idx, rd_idx, top_idx;
  logic [CW-1:0] cnt_w;
  logic [AW-1:0] wr_data;

  pcstk_rstsync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pcstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .call_push(call_push), .ret_pop(ret_pop), .rti_pop(rti_pop),
    .mv_read(mv_read), .mv_write(mv_write), .mv_reg(mv_reg),
    .wr_en(wr_en), .wr_idx(wr_idx), .rd_cap(rd_cap), .rd_idx(rd_idx),
    .top_idx(top_idx), .top_vld(top_vld), .cnt(cnt_w), .pend(pend_w),
    .ovf_err(ovf_err), .unf_err(unf_err), .reg_err(reg_err),
    .rti_hazard(rti_hazard)
  );

  assign wr_data = call_push ? call_addr : mv_wdata;

  pcstk_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_cap(rd_cap), .rd_idx(rd_idx),
    .top_idx(top_idx), .top_vld(top_vld),
    .top_addr(top_addr), .rd_data(mv_rdata)
  );

  assign stk_empty = (cnt_w == '0);
  assign stk_full  = (cnt_w == CW'(DEPTH));
endmodule

// File: rtl/pcstk_chk.sv
module pcstk_chk
  import pcstk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 14,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             call_push,
  input logic             ret_pop,
  input logic             rti_pop,
  input logic             mv_read,
  input logic             mv_write,
  input logic [REG_W-1:0] mv_reg,
  input logic [AW-1:0]    mv_wdata,
  input logic [AW-1:0]    top_addr,
  input logic [AW-1:0]    mv_rdata,
  input logic             stk_full,
  input logic             ovf_err,
  input logic             reg_err,
  input logic             rti_hazard,
  input logic             pend,
  input logic [CW-1:0]    cnt
);
  // decoder rule assumed by the checks below
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({call_push, ret_pop, rti_pop, mv_read, mv_write}));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_full && call_push && !pend) |=> (ovf_err && top_addr == $past(top_addr)));

  // R6
  rd_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_read && reg_code_ok(mv_reg) && !pend && cnt != '0)
      |=> (pend && cnt == $past(cnt)));

  // R6
  pend_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && cnt != '0 && !call_push && !ret_pop && !rti_pop && !mv_write)
      |=> (cnt == $past(cnt) - 1'b1));

  // R7
  wr_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_write && reg_code_ok(mv_reg) && !pend && !stk_full)
      |=> (top_addr == $past(mv_wdata)));

  // R10
  reg_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mv_read || mv_write) && !reg_code_ok(mv_reg) && !pend)
      |=> (reg_err && $stable(cnt) && $stable(mv_rdata) && !pend));

  // R9
  rti_hazard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_pop && pend) |=> rti_hazard);
endmodule

bind pcstk_top pcstk_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .call_push(call_push), .ret_pop(ret_pop), .rti_pop(rti_pop),
  .mv_read(mv_read), .mv_write(mv_write), .mv_reg(mv_reg),
  .mv_wdata(mv_wdata), .top_addr(top_addr), .mv_rdata(mv_rdata),
  .stk_full(stk_full), .ovf_err(ovf_err), .reg_err(reg_err),
  .rti_hazard(rti_hazard), .pend(pend_w), .cnt(cnt_w)
);

// File: tb/pcstk_top_tb.sv
module pcstk_top_tb;
  localparam int DEPTH = 16;
  localparam int AW    = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          call_push = 0, ret_pop = 0, rti_pop = 0, mv_read = 0, mv_write = 0;
  logic [AW-1:0] call_addr = '0, mv_wdata = '0;
  logic [5:0]    mv_reg = '0;
  logic [AW-1:0] top_addr, mv_rdata;
  logic          stk_empty, stk_full, ovf_err, unf_err, reg_err, rti_hazard;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model
  logic [AW-1:0] q[$];
  bit            m_pend = 0;
  logic [AW-1:0] m_rdata = '0;
  bit            m_ovf = 0, m_unf = 0, m_rerr = 0, m_haz = 0;

  always #5 clk = ~clk;

  pcstk_top #(.DEPTH(DEPTH), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .call_push(call_push), .call_addr(call_addr),
    .ret_pop(ret_pop), .rti_pop(rti_pop), .mv_read(mv_read), .mv_write(mv_write),
    .mv_reg(mv_reg), .mv_wdata(mv_wdata), .top_addr(top_addr), .mv_rdata(mv_rdata),
    .stk_empty(stk_empty), .stk_full(stk_full), .ovf_err(ovf_err), .unf_err(unf_err),
    .reg_err(reg_err), .rti_hazard(rti_hazard)
  );

  function automatic bit code_ok(input int c);
    return (c < 16) || ((c % 16) < 8);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string ctx);
    logic [AW-1:0] et;
    et = (q.size() == 0) ? '0 : q[q.size()-1];
    chk({ctx, " R2 R4 R7 R8 top_addr"}, 32'(top_addr), 32'(et));
    chk({ctx, " R2 stk_empty"}, 32'(stk_empty), 32'(q.size() == 0));
    chk({ctx, " R2 stk_full"}, 32'(stk_full), 32'(q.size() == DEPTH));
    chk({ctx, " R6 R4 mv_rdata"}, 32'(mv_rdata), 32'(m_rdata));
    chk({ctx, " R3 ovf_err"}, 32'(ovf_err), 32'(m_ovf));
    chk({ctx, " R5 R11 unf_err"}, 32'(unf_err), 32'(m_unf));
    chk({ctx, " R10 reg_err"}, 32'(reg_err), 32'(m_rerr));
    chk({ctx, " R9 rti_hazard"}, 32'(rti_hazard), 32'(m_haz));
  endtask

  // cmd: 0 idle, 1 call, 2 ret, 3 rti, 4 read move, 5 write move
  task automatic cyc(input int cmd, input logic [AW-1:0] a, input int r);
    bit old_pend, ok;
    @(negedge clk);
    compare_all("cycle");
    call_push = (cmd == 1); ret_pop = (cmd == 2); rti_pop = (cmd == 3);
    mv_read = (cmd == 4); mv_write = (cmd == 5);
    call_addr = a; mv_wdata = a; mv_reg = 6'(r);
    ok = code_ok(r);
    old_pend = m_pend;
    m_ovf = 0; m_unf = 0; m_rerr = 0; m_haz = 0; m_pend = 0;
    if (old_pend) begin
      if (q.size() == 0) m_unf = 1; else void'(q.pop_back());
    end
    if (cmd == 3 && old_pend) m_haz = 1;
    if (cmd == 2 || cmd == 3) begin
      if (q.size() == 0) m_unf = 1; else void'(q.pop_back());
    end
    if (cmd == 4 || cmd == 5) m_rerr = !ok;
    if (cmd == 4 && ok) begin
      if (q.size() == 0) m_unf = 1;
      else begin m_rdata = q[q.size()-1]; m_pend = 1; end
    end
    if (cmd == 1 || (cmd == 5 && ok)) begin
      if (q.size() == DEPTH) m_ovf = 1; else q.push_back(a);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, held and after release
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare_all("R1 after release");

    // R2 R3: fill past full
    for (int i = 0; i < DEPTH + 2; i++) cyc(1, AW'(14'h100 + i), 0);
    cyc(5, 14'h3AB, 3);                 // R3 write move into full stack
    // R4 R5: drain past empty
    for (int i = 0; i < DEPTH + 2; i++) cyc(2, '0, 0);
    cyc(3, '0, 0);                      // R5 rti on empty
    cyc(4, '0, 5);                      // R11 read move on empty
    // R6 R7: write then read with idle
    cyc(5, 14'h0A1, 20);
    cyc(5, 14'h0B2, 40);
    cyc(4, '0, 12);
    cyc(0, '0, 0);
    cyc(0, '0, 0);
    // R8: read then push in the next cycle
    cyc(4, '0, 1);
    cyc(1, 14'h0C3, 0);
    cyc(0, '0, 0);
    // R8: back-to-back reads
    cyc(5, 14'h0D4, 0);
    cyc(4, '0, 2);
    cyc(4, '0, 2);
    cyc(0, '0, 0);
    // R9: read directly before rti
    for (int i = 0; i < 4; i++) cyc(1, AW'(14'h200 + i), 0);
    cyc(4, '0, 7);
    cyc(3, '0, 0);
    cyc(0, '0, 0);
    // R10: refused codes on both moves
    cyc(4, '0, 24);
    cyc(5, 14'h3FF, 31);
    cyc(5, 14'h3FE, 63);
    cyc(4, '0, 56);
    cyc(0, '0, 0);

    // random phase, one command per cycle
    for (int n = 0; n < 6000; n++) begin
      int s, c;
      s = $urandom_range(0, 9);
      case (s)
        0: c = 0;
        1, 2: c = 1;
        3, 9: c = 2;
        4: c = 3;
        5, 6: c = 4;
        default: c = 5;
      endcase
      cyc(c, AW'($urandom), $urandom_range(0, 63));
    end
    cyc(0, '0, 0);
    @(negedge clk);
    compare_all("final");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule